// File: doc/BRIEF.md
# Hot-swap fault sequencing controller

This is the digital sequencing core of a hot-swap power switch. Its inputs are comparator flags that have already been digitized:
- supply lockout valid
- undervoltage
- input below the lower reset level
- overvoltage
- overcurrent (the switch is in current limit)
- feedback above the power-good level
- gate drive sufficient

The block decides when the pass switch may be enabled and when it must be forced off. It also decides when a fault is reported and when the output is declared good. All timing is counted in clock cycles. A single parameter gives the number of cycles per millisecond, and the qualification, overcurrent and cooldown durations are set in milliseconds on top of it.

After power-up the supply must be valid, with no undervoltage and no overvoltage, for an uninterrupted qualification window before the switch is enabled. A sustained overcurrent turns the switch off and latches a fault. The latch is cleared only by holding the reset-level flag, which comes from pulling the undervoltage input down hard, and then releasing it. A cooldown and then a fresh qualification follow before the switch returns.

When the fault output is looped back onto the undervoltage and reset-level inputs, the block retries on its own at a fixed period.

Top module: `hotswap_seq`

## Requirements
- R1: The gate enable rises only after the "supply ok, no undervoltage, no overvoltage" condition has been seen for QUAL_MS*CYC_PER_MS consecutive synchronized cycles. Any single cycle without the condition restarts the count. From an input change, the gate output responds on the QUAL_CYC+2nd clock edge, which includes two synchronizer stages.
- R2: While the switch is on, an overcurrent flag held for OC_MS*CYC_PER_MS synchronized cycles removes the gate enable and raises the fault output. Both outputs change on edge OC_CYC+2 after the flag rises.
- R3: An overcurrent flag that drops before the timeout clears the overcurrent count. Two pulses that are each one cycle short of the timeout, with a gap between them, do not trip the switch.
- R4: After an overcurrent trip the fault stays high and the gate stays low indefinitely. No retry happens while the reset-level flag stays low.
- R5: The fault clears only after the reset-level flag has been held for RST_HOLD_CYC consecutive synchronized cycles; a shorter hold is ignored. The fault drops on edge RST_HOLD_CYC+2 after the flag rises.
- R6: Releasing the reset-level flag after a cleared fault starts a cooldown of COOL_MS*CYC_PER_MS cycles, followed by a fresh qualification. The gate rises on edge COOL_CYC+QUAL_CYC+3 after the release.
- R7: Undervoltage or overvoltage while on removes the gate enable on the third edge. No fault is raised, and the switch requalifies by itself once the condition clears.
- R8: A supply lockout, which is the supply-valid flag low, raises the fast-pulldown output on the second edge and removes the gate enable on the third. The fast-pulldown output is high during reset.
- R9: Power-good rises only when both feedback-above and gate-drive-sufficient are set, on the third edge. A later drop of gate-drive-sufficient alone keeps it high, and a drop of feedback-above clears it on the third edge.
- R10: With the fault output fed back onto both the undervoltage and the reset-level inputs and overcurrent persisting, the controller repeats trips with a period of RST_HOLD_CYC+5+COOL_CYC+QUAL_CYC+OC_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| uvlo_ok_i | input | 1 | Supply lockout reports valid supply |
| uv_i | input | 1 | Undervoltage condition |
| uv_rst_i | input | 1 | Undervoltage input below the reset level |
| ov_i | input | 1 | Overvoltage condition |
| oc_i | input | 1 | Overcurrent, switch in current limit |
| fb_ok_i | input | 1 | Feedback above power-good level |
| gate_ok_i | input | 1 | Gate drive sufficient |
| gate_en_o | output | 1 | Gate enable request |
| fast_pd_o | output | 1 | Fast gate pulldown request |
| fault_o | output | 1 | Overcurrent fault, active high |
| pgood_o | output | 1 | Power good |

## Verification
The bench builds the controller with CYC_PER_MS=4 and RST_HOLD_CYC=3. These values shrink the qualification and cooldown windows to 400 cycles and the overcurrent timeout to 8 cycles. With windows that short, every transition can be checked on its exact clock edge, including one edge before and one edge after each boundary. Two complete auto-retry periods of 816 cycles, with their exact spacing, also fit in a short run.

// File: rtl/hotswap_seq.sv
module hotswap_seq #(
  parameter int CYC_PER_MS   = 125000,
  parameter int QUAL_MS      = 100,
  parameter int OC_MS        = 2,
  parameter int COOL_MS      = 100,
  parameter int RST_HOLD_CYC = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic uvlo_ok_i,
  input  logic uv_i,
  input  logic uv_rst_i,
  input  logic ov_i,
  input  logic oc_i,
  input  logic fb_ok_i,
  input  logic gate_ok_i,
  output logic gate_en_o,
  output logic fast_pd_o,
  output logic fault_o,
  output logic pgood_o
);
  localparam int QUAL_CYC = QUAL_MS * CYC_PER_MS;
  localparam int OC_CYC   = OC_MS * CYC_PER_MS;
  localparam int COOL_CYC = COOL_MS * CYC_PER_MS;
  localparam int MAX_A    = (QUAL_CYC > COOL_CYC) ? QUAL_CYC : COOL_CYC;
  localparam int MAX_B    = (OC_CYC > RST_HOLD_CYC) ? OC_CYC : RST_HOLD_CYC;
  localparam int MAX_CYC  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW       = $clog2(MAX_CYC + 1);
  localparam logic [CW-1:0] QUAL_END = CW'(QUAL_CYC - 1);
  localparam logic [CW-1:0] OC_END   = CW'(OC_CYC - 1);
  localparam logic [CW-1:0] COOL_END = CW'(COOL_CYC - 1);
  localparam logic [CW-1:0] RST_END  = CW'(RST_HOLD_CYC - 1);

  typedef enum logic [2:0] {S_QUAL, S_ON, S_LATCH, S_ARMED, S_COOL} st_t;

  logic [6:0] s1, s2;
  logic       uvlo_s, uv_s, rst_s, ov_s, oc_s, fb_s, gok_s, ok_s;
  st_t        st;
  logic [CW-1:0] tmr;
  logic       pg;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= {gate_ok_i, fb_ok_i, oc_i, ov_i, uv_rst_i, uv_i, uvlo_ok_i};
      s2 <= s1;
    end

  assign {gok_s, fb_s, oc_s, ov_s, rst_s, uv_s, uvlo_s} = s2;
  assign ok_s = uvlo_s & ~uv_s & ~ov_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st  <= S_QUAL;
      tmr <= '0;
      pg  <= 1'b0;
    end else begin
      pg <= fb_s & (pg | gok_s);
      case (st)
        S_QUAL:
          if (!ok_s) tmr <= '0;
          else if (tmr == QUAL_END) begin
            st  <= S_ON;
            tmr <= '0;
          end else tmr <= tmr + 1'b1;
        S_ON:
          if (!ok_s) begin
            st  <= S_QUAL;
            tmr <= '0;
          end else if (!oc_s) tmr <= '0;
          else if (tmr == OC_END) begin
            st  <= S_LATCH;
            tmr <= '0;
          end else tmr <= tmr + 1'b1;
        S_LATCH:
          if (!rst_s) tmr <= '0;
          else if (tmr == RST_END) begin
            st  <= S_ARMED;
            tmr <= '0;
          end else tmr <= tmr + 1'b1;
        S_ARMED:
          if (!rst_s) begin
            st  <= S_COOL;
            tmr <= '0;
          end
        S_COOL:
          if (tmr == COOL_END) begin
            st  <= S_QUAL;
            tmr <= '0;
          end else tmr <= tmr + 1'b1;
        default: begin
          st  <= S_QUAL;
          tmr <= '0;
        end
      endcase
    end

  assign gate_en_o = (st == S_ON);
  assign fault_o   = (st == S_LATCH);
  assign fast_pd_o = ~uvlo_s;
  assign pgood_o   = pg;
endmodule

// File: rtl/hotswap_seq_chk.sv
module hotswap_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic gate_en_o,
  input logic fault_o,
  input logic fast_pd_o,
  input logic pgood_o,
  input logic ok_s,
  input logic oc_s,
  input logic rst_s,
  input logic fb_s,
  input logic gok_s
);
  a_r2_trip_from_on: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_o) |-> $past(gate_en_o) && $past(oc_s));
  a_r5_clear_needs_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_o) |-> $past(rst_s));
  a_r8_lockout_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
    fast_pd_o |=> !gate_en_o);
  a_r1_gate_needs_ok: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_en_o) |-> $past(ok_s));
  a_r9_pg_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pgood_o) |-> $past(fb_s) && $past(gok_s));
  a_r9_pg_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pgood_o) |-> !$past(fb_s));
endmodule

bind hotswap_seq hotswap_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .gate_en_o(gate_en_o), .fault_o(fault_o),
  .fast_pd_o(fast_pd_o), .pgood_o(pgood_o), .ok_s(ok_s), .oc_s(oc_s),
  .rst_s(rst_s), .fb_s(fb_s), .gok_s(gok_s)
);

// File: tb/hotswap_seq_tb_top.sv
module hotswap_seq_tb_top;
  localparam int CPM  = 4;
  localparam int Q    = 100 * CPM;
  localparam int OC   = 2 * CPM;
  localparam int COOL = 100 * CPM;
  localparam int RST  = 3;
  localparam int P    = RST + 5 + COOL + Q + OC;
  localparam int GATE = 0, FAULT = 1, FPD = 2, PG = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic uvlo_ok = 1'b0, uv_drv = 1'b0, urst_drv = 1'b0, ov = 1'b0, oc = 1'b0;
  logic fb = 1'b0, gok = 1'b0, loop_en = 1'b0;
  logic gate_en, fast_pd, fault, pgood;
  logic uv_in, urst_in;
  int cyc = 0;
  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  typedef struct { int at; int sel; bit val; string tag; } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign uv_in   = loop_en ? fault : uv_drv;
  assign urst_in = loop_en ? fault : urst_drv;

  hotswap_seq #(.CYC_PER_MS(CPM), .RST_HOLD_CYC(RST)) dut_i (
    .clk(clk), .rst_n(rst_n), .uvlo_ok_i(uvlo_ok), .uv_i(uv_in),
    .uv_rst_i(urst_in), .ov_i(ov), .oc_i(oc), .fb_ok_i(fb),
    .gate_ok_i(gok), .gate_en_o(gate_en), .fast_pd_o(fast_pd),
    .fault_o(fault), .pgood_o(pgood)
  );

  function automatic bit pick(int sel);
    case (sel)
      GATE:    return gate_en;
      FAULT:   return fault;
      FPD:     return fast_pd;
      default: return pgood;
    endcase
  endfunction

  task automatic check_now(int sel, bit val, string tag);
    bit got = pick(sel);
    nchk++;
    if (got !== val) begin
      nfail++;
      $display("FAIL %s (cycle %0d sel %0d): got %0b expected %0b", tag, cyc, sel, got, val);
    end
  endtask

  task automatic push(int k, int sel, bit val, string tag);
    exp_t e;
    int i = 0;
    e.at = cyc + k; e.sel = sel; e.val = val; e.tag = tag;
    while (i < q.size() && q[i].at <= e.at) i++;
    q.insert(i, e);
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk)
    while (q.size() > 0 && q[0].at <= cyc) begin
      if (q[0].at < cyc) begin
        nchk++; nfail++;
        $display("FAIL %s: missed sample at %0d, actual n/a expected %0b", q[0].tag, q[0].at, q[0].val);
      end else check_now(q[0].sel, q[0].val, q[0].tag);
      void'(q.pop_front());
    end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    step(5);
    check_now(GATE, 0, "R1 reset gate");
    check_now(FAULT, 0, "R4 reset fault");
    check_now(PG, 0, "R9 reset pgood");
    check_now(FPD, 1, "R8 reset pulldown");
    rst_n = 1'b1;
    step(2);

    uvlo_ok = 1'b1;
    push(1, FPD, 1, "R8 pulldown before sync");
    push(2, FPD, 0, "R8 pulldown release");
    push(Q + 1, GATE, 0, "R1 gate before window");
    push(Q + 2, GATE, 1, "R1 gate after window");
    step(Q + 5);

    uv_drv = 1'b1;
    push(2, GATE, 1, "R7 uv gate still on");
    push(3, GATE, 0, "R7 uv gate off");
    push(3, FAULT, 0, "R7 uv no fault");
    step(10);
    uv_drv = 1'b0;
    step(100);
    ov = 1'b1;
    push(Q - 98, GATE, 0, "R1 glitch restarts count");
    push(Q + 2, GATE, 0, "R1 gate before restarted window");
    push(Q + 3, GATE, 1, "R1 gate after restarted window");
    step(1);
    ov = 1'b0;
    step(Q + 5);

    ov = 1'b1;
    push(3, GATE, 0, "R7 ov gate off");
    push(3, FAULT, 0, "R7 ov no fault");
    step(10);
    ov = 1'b0;
    push(Q + 2, GATE, 1, "R7 ov requalified");
    step(Q + 5);

    uvlo_ok = 1'b0;
    push(1, FPD, 0, "R8 pulldown before sync");
    push(2, FPD, 1, "R8 pulldown on");
    push(2, GATE, 1, "R8 gate before off");
    push(3, GATE, 0, "R8 gate off");
    push(3, FAULT, 0, "R8 no fault");
    step(10);
    uvlo_ok = 1'b1;
    push(2, FPD, 0, "R8 pulldown released");
    push(Q + 2, GATE, 1, "R8 requalified");
    step(Q + 5);

    oc = 1'b1; step(OC - 1); oc = 1'b0;
    step(3);
    oc = 1'b1; step(OC - 1); oc = 1'b0;
    push(OC + 5, FAULT, 0, "R3 short pulses no fault");
    push(OC + 5, GATE, 1, "R3 short pulses gate on");
    step(OC + 8);

    oc = 1'b1;
    push(OC + 1, FAULT, 0, "R2 before timeout");
    push(OC + 1, GATE, 1, "R2 gate before timeout");
    push(OC + 2, FAULT, 1, "R2 fault at timeout");
    push(OC + 2, GATE, 0, "R2 gate off at timeout");
    step(20);
    oc = 1'b0;
    step(COOL + Q + 20);
    push(1, FAULT, 1, "R4 still latched");
    push(1, GATE, 0, "R4 no self retry");
    step(5);

    uv_drv = 1'b1; urst_drv = 1'b1;
    step(RST - 1);
    urst_drv = 1'b0;
    push(5, FAULT, 1, "R5 short hold ignored");
    step(10);
    urst_drv = 1'b1;
    push(RST + 1, FAULT, 1, "R5 fault before hold done");
    push(RST + 2, FAULT, 0, "R5 fault cleared");
    push(RST + 2, GATE, 0, "R5 gate stays off");
    step(20);
    urst_drv = 1'b0; uv_drv = 1'b0;
    push(Q + 10, GATE, 0, "R6 in cooldown");
    push(COOL + Q + 2, GATE, 0, "R6 before cooldown plus window");
    push(COOL + Q + 3, GATE, 1, "R6 on after cooldown plus window");
    step(COOL + Q + 8);

    fb = 1'b1;
    push(5, PG, 0, "R9 no gate drive");
    step(6);
    gok = 1'b1;
    push(2, PG, 0, "R9 before rise");
    push(3, PG, 1, "R9 rise");
    step(6);
    gok = 1'b0;
    push(6, PG, 1, "R9 gate drive drop kept");
    step(8);
    fb = 1'b0;
    push(2, PG, 1, "R9 before fall");
    push(3, PG, 0, "R9 fall");
    step(6);

    loop_en = 1'b1; oc = 1'b1;
    push(OC + 2, FAULT, 1, "R10 first trip");
    push(OC + 2 + RST + 1, FAULT, 1, "R10 hold before clear");
    push(OC + 2 + RST + 2, FAULT, 0, "R10 self clear");
    push(OC + 2 + P - OC - 1, GATE, 0, "R10 before retry");
    push(OC + 2 + P - OC, GATE, 1, "R10 retry on");
    push(OC + 2 + P - 1, FAULT, 0, "R10 before second trip");
    push(OC + 2 + P, FAULT, 1, "R10 second trip");
    push(OC + 2 + 2 * P - OC, GATE, 1, "R10 second retry on");
    push(OC + 2 + 2 * P, FAULT, 1, "R10 third trip");
    step(OC + 2 + 2 * P + 5);
    while (q.size() > 0) @(negedge clk);
    finish_run();
  end
endmodule